// File: doc/BRIEF.md
# Tic-tac-toe win detector

This block inspects a 3x3 noughts-and-crosses board and reports, for each player, whether that player holds a complete line. Each square has two occupancy bits: one for the X player and one for the O player. Nothing is clocked or registered. The outputs follow the board inputs combinationally. The block suits a game controller that samples the board after each move.

One line-matching circuit is written once and instantiated twice. One copy takes the X bits and the other takes the O bits. Each copy gives a win flag and an 8-bit mask of the lines that are complete. A small guard stage raises an illegal-board flag in two cases: a square is claimed by both players, or both players show a win at the same time. The line geometry is computed from a side-length parameter rather than written out as a table.

Top module: `tttWinDetect`

## Requirements
- R1: Squares are numbered 1 to 9 in row-major order, and square n is carried on bit n-1 of `xMarks` and of `oMarks`.
- R2: Row lines map to mask bits 0, 1 and 2, covering squares {1,2,3}, {4,5,6} and {7,8,9}.
- R3: Column lines map to mask bits 3, 4 and 5, covering squares {1,4,7}, {2,5,8} and {3,6,9}.
- R4: Mask bit 6 is the diagonal {1,5,9} and mask bit 7 is the anti-diagonal {3,5,7}.
- R5: A player's win flag is 1 exactly when at least one of that player's mask bits is set. A player with fewer than three marks, or with marks that form no full line, shows a zero mask and no win.
- R6: Several mask bits may be set together, and a fully marked board sets all eight bits.
- R7: The O outputs decode the O bits with the same mapping as the X outputs, and each player's outputs do not depend on the other player's bits.
- R8: `illegal` is 1 whenever any square has both its X bit and its O bit set.
- R9: `illegal` is 1 whenever `xWin` and `oWin` are both 1.
- R10: `illegal` is 0 when there is no shared square and at most one player wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xMarks | input | 9 | X occupancy, square n on bit n-1 |
| oMarks | input | 9 | O occupancy, square n on bit n-1 |
| xWin | output | 1 | X holds at least one complete line |
| oWin | output | 1 | O holds at least one complete line |
| xLines | output | 8 | Complete lines for X (rows, columns, diagonals) |
| oLines | output | 8 | Complete lines for O |
| illegal | output | 1 | Shared square or simultaneous wins |

## Verification
The assertions check the following on every evaluation:
- A player with fewer than three marks never shows a line or a win.
- A full player board lights every line.
- A shared square or a double win always raises `illegal`.
- A clear `illegal` never coexists with a shared square.

The bench scenarios are needed for the rest. Only they show that each mask bit corresponds to its own squares, that the two players stay independent, and that near-miss positions in a realistic game produce no win.

// File: rtl/tttPkg.sv
package tttPkg;

  // Strobes passed from the line datapath to the guard control.
  typedef struct packed {
    logic xWin;
    logic oWin;
    logic clash;
  } guardStrobe_t;

  // Square index (0-based, row-major) of member k of line l on a side x side board.
  // Lines: rows first, then columns, then main diagonal, then anti-diagonal.
  function automatic int sqOf(input int l, input int k, input int side);
    if (l < side)            return l * side + k;
    else if (l < 2 * side)   return k * side + (l - side);
    else if (l == 2 * side)  return k * side + k;
    else                     return k * side + (side - 1 - k);
  endfunction

endpackage

// File: rtl/lineMatch.sv
module lineMatch #(
  parameter int SIDE = 3,
  localparam int SQ = SIDE * SIDE,
  localparam int LN = 2 * SIDE + 2
) (
  input  logic [SQ-1:0] marks,
  output logic [LN-1:0] lines,
  output logic          win
);
  import tttPkg::*;

  logic [LN-1:0] term;

  // One AND term per line, built from the computed geometry.
  for (genvar l = 0; l < LN; l++) begin : g_line
    logic [SIDE-1:0] member;
    for (genvar k = 0; k < SIDE; k++) begin : g_member
      assign member[k] = marks[sqOf(l, k, SIDE)];
    end
    assign term[l] = &member;
  end

  assign lines = term;
  assign win   = |term;

  always_comb begin
    if ($countones(marks) < SIDE)
      p_few_marks_r5: assert (lines == '0 && !win)
        else $error("line reported with fewer than SIDE marks");
    if (&marks)
      p_full_board_r6: assert (&lines && win)
        else $error("full board does not light every line");
  end

endmodule

// File: rtl/boardGuard.sv
module boardGuard
  import tttPkg::*;
(
  input  guardStrobe_t strobe,
  output logic         illegal
);

  assign illegal = strobe.clash | (strobe.xWin & strobe.oWin);

  always_comb begin
    if (strobe.clash)
      p_clash_r8: assert (illegal) else $error("shared square not flagged");
    if (strobe.xWin && strobe.oWin)
      p_double_win_r9: assert (illegal) else $error("double win not flagged");
  end

endmodule

// File: rtl/tttWinDetect.sv
module tttWinDetect #(
  parameter int SIDE = 3,
  localparam int SQ = SIDE * SIDE,
  localparam int LN = 2 * SIDE + 2
) (
  input  logic [SQ-1:0] xMarks,
  input  logic [SQ-1:0] oMarks,
  output logic          xWin,
  output logic          oWin,
  output logic [LN-1:0] xLines,
  output logic [LN-1:0] oLines,
  output logic          illegal
);
  import tttPkg::*;

  logic [1:0][SQ-1:0] playerMarks;
  logic [1:0][LN-1:0] playerLines;
  logic [1:0]         playerWin;
  guardStrobe_t       strobe;

  assign playerMarks[0] = xMarks;
  assign playerMarks[1] = oMarks;

  for (genvar p = 0; p < 2; p++) begin : g_player
    lineMatch #(.SIDE(SIDE)) u_match (
      .marks(playerMarks[p]),
      .lines(playerLines[p]),
      .win  (playerWin[p])
    );
  end

  assign xLines = playerLines[0];
  assign oLines = playerLines[1];
  assign xWin   = playerWin[0];
  assign oWin   = playerWin[1];

  assign strobe.xWin  = playerWin[0];
  assign strobe.oWin  = playerWin[1];
  assign strobe.clash = |(xMarks & oMarks);

  boardGuard u_guard (
    .strobe (strobe),
    .illegal(illegal)
  );

  always_comb begin
    if (!illegal)
      p_no_silent_clash_r10: assert ((xMarks & oMarks) == '0 && !(xWin && oWin))
        else $error("legal flag with shared square or double win");
  end

endmodule

// File: tb/sim_tttWinDetect.sv
module sim_tttWinDetect;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [8:0] xMarks, oMarks;
  logic       xWin, oWin, illegal;
  logic [7:0] xLines, oLines;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  tttWinDetect u0 (
    .xMarks (xMarks),
    .oMarks (oMarks),
    .xWin   (xWin),
    .oWin   (oWin),
    .xLines (xLines),
    .oLines (oLines),
    .illegal(illegal)
  );

  // {x[8:0], o[8:0], xLines[7:0], oLines[7:0], illegal}; square n on bit n-1
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {9'b000000000, 9'b000000000, 8'h00, 8'h00, 1'b0},  // empty board
    {9'b000000111, 9'b000000000, 8'h01, 8'h00, 1'b0},  // R2 row {1,2,3}
    {9'b000111000, 9'b000000000, 8'h02, 8'h00, 1'b0},  // R2 row {4,5,6}
    {9'b111000000, 9'b000000000, 8'h04, 8'h00, 1'b0},  // R2 row {7,8,9}
    {9'b001001001, 9'b000000000, 8'h08, 8'h00, 1'b0},  // R3 col {1,4,7}
    {9'b000000000, 9'b010010010, 8'h00, 8'h10, 1'b0},  // R3 R7 col {2,5,8}
    {9'b000000000, 9'b100100100, 8'h00, 8'h20, 1'b0},  // R3 R7 col {3,6,9}
    {9'b000000000, 9'b100010001, 8'h00, 8'h40, 1'b0},  // R4 R7 diag
    {9'b000000000, 9'b001010100, 8'h00, 8'h80, 1'b0},  // R4 R7 anti-diag
    {9'b111111111, 9'b000000000, 8'hFF, 8'h00, 1'b0},  // R6 full board
    {9'b001001111, 9'b000000000, 8'h09, 8'h00, 1'b0},  // R6 row+col
    {9'b010110001, 9'b100001110, 8'h00, 8'h00, 1'b0},  // R5 near miss game
    {9'b100010001, 9'b000000110, 8'h40, 8'h00, 1'b0},  // R10 legal X win
    {9'b000010000, 9'b000010000, 8'h00, 8'h00, 1'b1},  // R8 shared centre
    {9'b000000111, 9'b111000000, 8'h01, 8'h04, 1'b1},  // R9 both win
    {9'b000111000, 9'b000111000, 8'h02, 8'h02, 1'b1}   // R8 R9 same row
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [8:0] x, input logic [8:0] o);
    @(negedge clk);
    xMarks = x;
    oMarks = o;
    #5;
  endtask

  initial begin
    xMarks = '0;
    oMarks = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset state: empty board shows nothing
    apply('0, '0);
    check("R5 reset xWin", {31'd0, xWin}, 32'd0);
    check("R5 reset oWin", {31'd0, oWin}, 32'd0);
    check("R10 reset illegal", {31'd0, illegal}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      apply(v[34:26], v[25:17]);
      check("R1-map xLines (R2 R3 R4)", {24'd0, xLines}, {24'd0, v[16:9]});
      check("R7 oLines", {24'd0, oLines}, {24'd0, v[8:1]});
      check("R5 xWin", {31'd0, xWin}, {31'd0, |v[16:9]});
      check("R5 oWin", {31'd0, oWin}, {31'd0, |v[8:1]});
      check("R8 R9 R10 illegal", {31'd0, illegal}, {31'd0, v[0]});
    end

    // R1 each square alone claimed by both players flags illegal, no line
    for (int s = 0; s < 9; s++) begin
      apply(9'(1 << s), 9'(1 << s));
      check("R8 single clash", {31'd0, illegal}, 32'd1);
      check("R5 single mark no line", {24'd0, xLines}, 32'd0);
    end

    // R7 independence: X row stays while O bits vary on other squares
    apply(9'b000000111, 9'b000011000);
    check("R7 x unaffected", {24'd0, xLines}, 32'h01);
    check("R7 o partial", {24'd0, oLines}, 32'h00);

    // R1 bit order: squares 7,8,9 on the high bits only
    apply(9'b111000000, 9'b000000111);
    check("R1 X top bits row3", {24'd0, xLines}, 32'h04);
    check("R1 O low bits row1", {24'd0, oLines}, 32'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule